// File: doc/BRIEF.md
# Serial Port Transceiver with Flag Register and Line-Idle Wake

This block pairs an asynchronous serial transmitter with a receiver and exposes both through four byte-wide bus addresses. Two of them are control registers: one turns the transmit and receive halves on separately, and the other holds a receiver sleep request and a send-break request. A third address returns a status byte with seven flags. The fourth address is shared. Writing to it fills a transmit holding buffer. Reading from it returns a separate receive holding buffer, so data written there is never read back.

Characters use one start bit, eight data bits sent least significant bit first, no parity, and one stop bit. One bit time lasts `OVERSAMPLE * CLKS_PER_SAMPLE` clocks. The receiver samples the line sixteen times per bit and decides each bit by a majority of the three centre samples. Software may put the receiver to sleep, and the block clears that request by itself once the line has stayed high for a whole character time.

Top module: `uart_sci`

## Requirements
- R1: After reset the status byte reads 0xC0: bit 7 (transmit buffer empty) and bit 6 (transmit complete) are set, and bit 5 (receive full), bit 4 (idle), bit 3 (overrun), bit 2 (noise) and bit 1 (framing) are clear. `txLine` is high.
- R2: A write to address 3 queues a byte. With bit 0 of address 0 set, the byte leaves on `txLine` as a low start bit, eight data bits least significant bit first, and a high stop bit, each lasting 16 x `CLKS_PER_SAMPLE` clocks. A read of address 3 returns the last received byte, and a write to address 3 does not change that read value.
- R3: A data write clears status bits 7 and 6. Bit 7 sets again once the shifter has taken the byte, so a second byte can wait in the buffer while the first is sent. Bit 6 sets when a character ends and nothing is waiting to be sent.
- R4: With bit 1 of address 0 set, a character received on `rxLine` sets status bit 5, and the byte can then be read at address 3. The held byte does not change while bit 5 is set.
- R5: A character that ends while bit 5 is set sets status bit 3 (overrun). That character is dropped, and the earlier byte stays readable.
- R6: Status bit 2 (noise) sets when the three centre samples of any bit of a received character do not all agree. The byte is still decided by majority.
- R7: Status bit 1 (framing) sets when the stop bit is decided as low. The byte is still delivered.
- R8: Status bit 4 (idle) sets once, when the receive line has stayed high for ten bit times after it was last seen low.
- R9: Reading the status byte and then reading address 3 clears status bits 5, 4, 3, 2 and 1. A read of address 3 that comes without a status read before it, or that follows a data write, clears nothing.
- R10: Setting bit 0 of address 1 puts the receiver to sleep. While it sleeps, no receive flag is set. The hardware clears bit 0 after ten bit times of unbroken high level on the receive line, and characters are received normally after that.
- R11: While bit 1 of address 1 is set and the transmitter is enabled, `txLine` is held low in back-to-back ten-bit break characters with no high gap between them. After the bit is cleared, the line goes high again within one character time.
- R12: When the transmitter is disabled, `txLine` stays high even if a byte is queued. When the receiver is disabled, activity on `rxLine` sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busSel | input | 1 | Bus access strobe for this cycle |
| busWr | input | 1 | 1 for a write, 0 for a read |
| busAddr | input | 2 | 0 enables, 1 sleep/break, 2 status, 3 data |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for the addressed register |
| rxLine | input | 1 | Serial receive line, high at rest |
| txLine | output | 1 | Serial transmit line, high at rest |

## Verification
Some rules are checked by assertions on every cycle. The transmit line stays high when the transmitter is off. The receive buffer holds its value while it is full. Overrun can rise only when the buffer was already full. Sleep blocks any new receive-full flag, and the sleep bit only falls because of a wake event or a software write. Bit-exact framing, majority voting against a single-sample glitch, the ten-bit-time idle and wake windows, and the two-step flag clear cannot be seen one cycle at a time. Only the bench's scenarios show them, by comparing transmitted frames and status bytes with values it computes itself.

// File: rtl/uart_sci_pkg.sv
package uart_sci_pkg;

  localparam int DATA_W = 8;

  // status byte bit positions
  localparam int ST_TXE = 7;
  localparam int ST_TXC = 6;
  localparam int ST_RXF = 5;
  localparam int ST_IDL = 4;
  localparam int ST_OVR = 3;
  localparam int ST_NSE = 2;
  localparam int ST_FRM = 1;

  localparam logic [1:0] ADDR_CTLA = 2'd0;
  localparam logic [1:0] ADDR_CTLB = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;
  localparam logic [1:0] ADDR_DATA = 2'd3;

  // control -> datapath
  typedef struct packed {
    logic              txEn;
    logic              rxEn;
    logic              sleep;
    logic              sendBreak;
    logic              txHave;
    logic [DATA_W-1:0] txByte;
  } ctlStrobes_t;

  // datapath -> control
  typedef struct packed {
    logic              txTake;
    logic              txFinish;
    logic              rxDone;
    logic [DATA_W-1:0] rxByte;
    logic              rxNoise;
    logic              rxFrame;
    logic              idleSeen;
    logic              wake;
  } dpEvents_t;

endpackage

// File: rtl/uart_sci_datapath.sv
module uart_sci_datapath
  import uart_sci_pkg::*;
#(
  parameter int CLKS_PER_SAMPLE = 4,
  parameter int OVERSAMPLE      = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctlStrobes_t ctl,
  input  logic        rxLine,
  output logic        txLine,
  output dpEvents_t   evt
);

  localparam int PRE_W      = (CLKS_PER_SAMPLE > 1) ? $clog2(CLKS_PER_SAMPLE) : 1;
  localparam int BIT_CLKS   = CLKS_PER_SAMPLE * OVERSAMPLE;
  localparam int BCLK_W     = $clog2(BIT_CLKS);
  localparam int FRAME_BITS = DATA_W + 2;
  localparam int IDX_W      = $clog2(FRAME_BITS);
  localparam int SUB_W      = $clog2(OVERSAMPLE);
  localparam int MID        = OVERSAMPLE / 2;
  localparam int IDLE_TICKS = OVERSAMPLE * FRAME_BITS;
  localparam int MARK_W     = $clog2(IDLE_TICKS + 1);

  // ---------------- sample-rate prescaler ----------------
  logic [PRE_W-1:0] preCnt;
  logic             sampleTick;

  assign sampleTick = (preCnt == PRE_W'(CLKS_PER_SAMPLE - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           preCnt <= '0;
    else if (sampleTick) preCnt <= '0;
    else                 preCnt <= preCnt + 1'b1;
  end

  // ---------------- transmitter ----------------
  typedef enum logic [1:0] {TX_IDLE, TX_DATA, TX_BRK} txState_t;

  txState_t              txState;
  logic [FRAME_BITS-1:0] txShift;
  logic [IDX_W-1:0]      txIdx;
  logic [BCLK_W-1:0]     txClk;
  logic                  txLineQ;
  logic                  txFrameEnd;
  logic                  txTakeC;

  assign txFrameEnd = (txState != TX_IDLE) && (txClk == BCLK_W'(BIT_CLKS - 1))
                      && (txIdx == IDX_W'(FRAME_BITS - 1));
  assign txTakeC    = ctl.txEn && (txState == TX_IDLE) && !ctl.sendBreak && ctl.txHave;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txState <= TX_IDLE;
      txShift <= '1;
      txIdx   <= '0;
      txClk   <= '0;
      txLineQ <= 1'b1;
    end else if (!ctl.txEn) begin
      txState <= TX_IDLE;
      txIdx   <= '0;
      txClk   <= '0;
      txLineQ <= 1'b1;
    end else begin
      case (txState)
        TX_IDLE: begin
          txIdx <= '0;
          txClk <= '0;
          if (ctl.sendBreak) begin
            txState <= TX_BRK;
            txLineQ <= 1'b0;
          end else if (ctl.txHave) begin
            txState <= TX_DATA;
            txShift <= {1'b1, ctl.txByte, 1'b0};
            txLineQ <= 1'b0;
          end else begin
            txLineQ <= 1'b1;
          end
        end
        default: begin
          if (txClk == BCLK_W'(BIT_CLKS - 1)) begin
            txClk <= '0;
            if (txIdx == IDX_W'(FRAME_BITS - 1)) begin
              txIdx <= '0;
              if (ctl.sendBreak) begin
                txState <= TX_BRK;
                txLineQ <= 1'b0;
              end else begin
                txState <= TX_IDLE;
                txLineQ <= 1'b1;
              end
            end else begin
              txIdx   <= txIdx + 1'b1;
              txLineQ <= (txState == TX_BRK) ? 1'b0 : txShift[txIdx + 1'b1];
            end
          end else begin
            txClk <= txClk + 1'b1;
          end
        end
      endcase
    end
  end

  assign txLine = txLineQ;

  // R12: a disabled transmitter keeps the line at rest
  a_r12_tx_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.txEn |=> txLine);

  // ---------------- receiver ----------------
  logic [1:0]        rxSync;
  logic              rxBit;
  logic              rxBusy;
  logic [SUB_W-1:0]  rxSub;
  logic [IDX_W-1:0]  rxIdx;
  logic [1:0]        voteQ;
  logic              voteMaj;
  logic              voteDis;
  logic              noiseAcc;
  logic [DATA_W-1:0] rxData;
  logic              rxDoneQ;
  logic              rxNoiseQ;
  logic              rxFrameQ;
  logic [DATA_W-1:0] rxByteQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxSync <= 2'b11;
    else       rxSync <= {rxSync[0], rxLine};
  end
  assign rxBit = rxSync[1];

  assign voteMaj = (voteQ[0] & voteQ[1]) | (voteQ[0] & rxBit) | (voteQ[1] & rxBit);
  assign voteDis = !((voteQ[0] == voteQ[1]) && (voteQ[1] == rxBit));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxBusy   <= 1'b0;
      rxSub    <= '0;
      rxIdx    <= '0;
      voteQ    <= 2'b11;
      noiseAcc <= 1'b0;
      rxData   <= '0;
      rxDoneQ  <= 1'b0;
      rxNoiseQ <= 1'b0;
      rxFrameQ <= 1'b0;
      rxByteQ  <= '0;
    end else begin
      rxDoneQ <= 1'b0;
      if (!ctl.rxEn) begin
        rxBusy <= 1'b0;
        rxSub  <= '0;
        rxIdx  <= '0;
      end else if (sampleTick) begin
        if (!rxBusy) begin
          if (!rxBit) begin
            rxBusy   <= 1'b1;
            rxSub    <= '0;
            rxIdx    <= '0;
            noiseAcc <= 1'b0;
          end
        end else begin
          if (rxSub == SUB_W'(MID - 1)) voteQ[0] <= rxBit;
          if (rxSub == SUB_W'(MID))     voteQ[1] <= rxBit;
          if (rxSub == SUB_W'(MID + 1)) begin
            if (rxIdx == '0) begin
              if (voteMaj) rxBusy <= 1'b0;   // false start
              noiseAcc <= voteDis;
            end else if (rxIdx == IDX_W'(FRAME_BITS - 1)) begin
              rxBusy   <= 1'b0;
              rxDoneQ  <= 1'b1;
              rxFrameQ <= !voteMaj;
              rxNoiseQ <= noiseAcc | voteDis;
              rxByteQ  <= rxData;
            end else begin
              rxData   <= {voteMaj, rxData[DATA_W-1:1]};
              noiseAcc <= noiseAcc | voteDis;
            end
          end
          if (rxSub == SUB_W'(OVERSAMPLE - 1)) begin
            rxSub <= '0;
            rxIdx <= rxIdx + 1'b1;
          end else begin
            rxSub <= rxSub + 1'b1;
          end
        end
      end
    end
  end

  // ---------------- idle / wake detector ----------------
  logic [MARK_W-1:0] markCnt;
  logic              idleArmed;
  logic              sleepQ;
  logic              idleSeenQ;
  logic              wakeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      markCnt   <= '0;
      idleArmed <= 1'b0;
      sleepQ    <= 1'b0;
      idleSeenQ <= 1'b0;
      wakeQ     <= 1'b0;
    end else begin
      sleepQ    <= ctl.sleep;
      idleSeenQ <= 1'b0;
      wakeQ     <= 1'b0;
      if (!ctl.rxEn) begin
        markCnt   <= '0;
        idleArmed <= 1'b0;
      end else if (ctl.sleep && !sleepQ) begin
        markCnt <= '0;
      end else if (sampleTick) begin
        if (!rxBit) begin
          markCnt   <= '0;
          idleArmed <= 1'b1;
        end else if (markCnt != MARK_W'(IDLE_TICKS)) begin
          markCnt <= markCnt + 1'b1;
          if (markCnt == MARK_W'(IDLE_TICKS - 1)) begin
            idleSeenQ <= idleArmed;
            idleArmed <= 1'b0;
            wakeQ     <= ctl.sleep;
          end
        end
      end
    end
  end

  always_comb begin
    evt          = '0;
    evt.txTake   = txTakeC;
    evt.txFinish = ctl.txEn && txFrameEnd && !ctl.sendBreak && !ctl.txHave;
    evt.rxDone   = rxDoneQ;
    evt.rxByte   = rxByteQ;
    evt.rxNoise  = rxNoiseQ;
    evt.rxFrame  = rxFrameQ;
    evt.idleSeen = idleSeenQ;
    evt.wake     = wakeQ;
  end

endmodule

// File: rtl/uart_sci_ctrl.sv
module uart_sci_ctrl
  import uart_sci_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [1:0]        busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  dpEvents_t         evt,
  output ctlStrobes_t       ctl
);

  logic              txEnR, rxEnR, sleepR, breakR;
  logic [DATA_W-1:0] txBuf, rxBuf;
  logic              txEmpty, txDone;
  logic              rxFull, idleF, ovrF, noiseF, frameF;
  logic              armed;

  logic wrCtlA, wrCtlB, wrData, rdStat, rdData, clrRx, rxAccept;

  assign wrCtlA   = busSel &&  busWr && (busAddr == ADDR_CTLA);
  assign wrCtlB   = busSel &&  busWr && (busAddr == ADDR_CTLB);
  assign wrData   = busSel &&  busWr && (busAddr == ADDR_DATA);
  assign rdStat   = busSel && !busWr && (busAddr == ADDR_STAT);
  assign rdData   = busSel && !busWr && (busAddr == ADDR_DATA);
  assign clrRx    = rdData && armed;
  assign rxAccept = evt.rxDone && rxEnR && !sleepR;

  // control registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txEnR  <= 1'b0;
      rxEnR  <= 1'b0;
      sleepR <= 1'b0;
      breakR <= 1'b0;
    end else begin
      if (wrCtlA) begin
        txEnR <= busWdata[0];
        rxEnR <= busWdata[1];
      end
      if (wrCtlB) begin
        sleepR <= busWdata[0];
        breakR <= busWdata[1];
      end else if (evt.wake) begin
        sleepR <= 1'b0;
      end
    end
  end

  // transmit buffer and flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBuf   <= '0;
      txEmpty <= 1'b1;
      txDone  <= 1'b1;
    end else if (wrData) begin
      txBuf   <= busWdata;
      txEmpty <= 1'b0;
      txDone  <= 1'b0;
    end else begin
      if (evt.txTake)   txEmpty <= 1'b1;
      if (evt.txFinish) txDone  <= 1'b1;
    end
  end

  // receive buffer, flags and the two-step clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxBuf  <= '0;
      rxFull <= 1'b0;
      idleF  <= 1'b0;
      ovrF   <= 1'b0;
      noiseF <= 1'b0;
      frameF <= 1'b0;
      armed  <= 1'b0;
    end else begin
      if (rdStat)                                  armed <= 1'b1;
      else if (busSel && busAddr == ADDR_DATA)     armed <= 1'b0;
      if (clrRx) begin
        rxFull <= 1'b0;
        idleF  <= 1'b0;
        ovrF   <= 1'b0;
        noiseF <= 1'b0;
        frameF <= 1'b0;
      end
      if (rxAccept) begin
        if (rxFull) begin
          ovrF <= 1'b1;
        end else begin
          rxBuf  <= evt.rxByte;
          rxFull <= 1'b1;
          noiseF <= evt.rxNoise;
          frameF <= evt.rxFrame;
        end
      end
      if (evt.idleSeen && rxEnR && !sleepR) idleF <= 1'b1;
    end
  end

  // read mux
  always_comb begin
    busRdata = '0;
    case (busAddr)
      ADDR_CTLA: busRdata = {{(DATA_W-2){1'b0}}, rxEnR, txEnR};
      ADDR_CTLB: busRdata = {{(DATA_W-2){1'b0}}, breakR, sleepR};
      ADDR_STAT: begin
        busRdata[ST_TXE] = txEmpty;
        busRdata[ST_TXC] = txDone;
        busRdata[ST_RXF] = rxFull;
        busRdata[ST_IDL] = idleF;
        busRdata[ST_OVR] = ovrF;
        busRdata[ST_NSE] = noiseF;
        busRdata[ST_FRM] = frameF;
      end
      default:   busRdata = rxBuf;
    endcase
  end

  always_comb begin
    ctl           = '0;
    ctl.txEn      = txEnR;
    ctl.rxEn      = rxEnR;
    ctl.sleep     = sleepR;
    ctl.sendBreak = breakR;
    ctl.txHave    = !txEmpty;
    ctl.txByte    = txBuf;
  end

  // R4: a full receive buffer is never overwritten
  a_r4_buffer_held: assert property (@(posedge clk) disable iff (!rstN)
    rxFull |=> $stable(rxBuf));

  // R5: overrun only follows an already full buffer
  a_r5_overrun_needs_full: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovrF) |-> $past(rxFull));

  // R10: a sleeping receiver raises no receive-full flag
  a_r10_sleep_blocks: assert property (@(posedge clk) disable iff (!rstN)
    sleepR |=> !$rose(rxFull));

  // R10: sleep ends only through the wake event or a software write
  a_r10_sleep_release: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sleepR) |-> $past(evt.wake || wrCtlB));

  // R3: the empty flag returns only when the shifter takes the byte
  a_r3_empty_on_take: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txEmpty) |-> $past(evt.txTake));

endmodule

// File: rtl/uart_sci.sv
module uart_sci
  import uart_sci_pkg::*;
#(
  parameter int CLKS_PER_SAMPLE = 4,
  parameter int OVERSAMPLE      = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busSel,
  input  logic       busWr,
  input  logic [1:0] busAddr,
  input  logic [7:0] busWdata,
  output logic [7:0] busRdata,
  input  logic       rxLine,
  output logic       txLine
);

  ctlStrobes_t ctl;
  dpEvents_t   evt;

  uart_sci_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busSel   (busSel),
    .busWr    (busWr),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .evt      (evt),
    .ctl      (ctl)
  );

  uart_sci_datapath #(
    .CLKS_PER_SAMPLE (CLKS_PER_SAMPLE),
    .OVERSAMPLE      (OVERSAMPLE)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .rxLine (rxLine),
    .txLine (txLine),
    .evt    (evt)
  );

endmodule

// File: tb/uart_sci_bench.sv
`timescale 1ns/1ps
module uart_sci_bench;

  localparam int CPS      = 4;
  localparam int BIT_CLKS = CPS * 16;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busSel = 1'b0;
  logic       busWr = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic [7:0] busWdata = 8'd0;
  logic [7:0] busRdata;
  logic       rxLine = 1'b1;
  logic       txLine;

  int nChk = 0;
  int nBad = 0;

  always #10 clk = ~clk;

  uart_sci #(.CLKS_PER_SAMPLE(CPS), .OVERSAMPLE(16)) u_uart_sci (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .rxLine(rxLine), .txLine(txLine)
  );

  function automatic logic [9:0] expFrame(input logic [7:0] b);
    return {1'b1, b, 1'b0};
  endfunction

  function automatic logic [7:0] expRx(input logic full, input logic ovr,
                                       input logic nse, input logic frm);
    return {2'b00, full, 1'b0, ovr, nse, frm, 1'b0};
  endfunction

  task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk); busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #2 d = busRdata;
    @(negedge clk); busSel = 1'b0;
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // drive one character; glitchBit >= 0 flips one centre sample of that bit
  task automatic sendRx(input logic [7:0] b, input int glitchBit, input logic stopVal);
    for (int k = 0; k < 10; k++) begin
      logic v;
      v = (k == 0) ? 1'b0 : (k == 9) ? stopVal : b[k-1];
      for (int c = 0; c < BIT_CLKS; c++) begin
        @(negedge clk);
        rxLine = (k == glitchBit && c >= 38 && c < 42) ? ~v : v;
      end
    end
    @(negedge clk); rxLine = 1'b1;
  endtask

  task automatic captureTx(output logic [9:0] f);
    while (txLine !== 1'b0) @(negedge clk);
    waitClk(BIT_CLKS / 2);
    for (int k = 0; k < 10; k++) begin
      f[k] = txLine;
      if (k < 9) waitClk(BIT_CLKS);
    end
  endtask

  task automatic clearRx();
    logic [7:0] d;
    busRead(2'd2, d);
    busRead(2'd3, d);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    nChk++; nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [9:0] f;
    int unsigned seed;
    int bad;
    seed = $urandom(32'd4242);

    waitClk(4);
    rstN = 1'b1;
    waitClk(2);

    // R1 reset state
    busRead(2'd2, d);
    check("R1 status", {2'b0, d}, {2'b0, 8'hC0});
    check("R1 txLine", {9'b0, txLine}, 10'd1);

    busWrite(2'd0, 8'h03);

    // R2/R3 single byte transmit
    busWrite(2'd3, 8'hA5);
    waitClk(6);
    busRead(2'd2, d);
    check("R3 empty not done", {8'b0, d[7:6]}, 10'b10);
    captureTx(f);
    check("R2 frame A5", f, expFrame(8'hA5));
    waitClk(40);
    busRead(2'd2, d);
    check("R3 done", {8'b0, d[7:6]}, 10'b11);

    // R3 double buffering
    busWrite(2'd3, 8'h0F);
    busWrite(2'd3, 8'hF0);
    busRead(2'd2, d);
    check("R3 second waits", {9'b0, d[7]}, 10'd0);
    captureTx(f);
    check("R2 frame 0F", f, expFrame(8'h0F));
    captureTx(f);
    check("R2 frame F0", f, expFrame(8'hF0));
    waitClk(40);

    // R4/R9/R2 receive and two-step clear
    sendRx(8'h3C, -1, 1'b1);
    busRead(2'd2, d);
    check("R4 rx full", {2'b0, d & 8'h2E}, {2'b0, expRx(1, 0, 0, 0)});
    busWrite(2'd3, 8'h77);
    busRead(2'd3, d);
    check("R2 rx buffer separate", {2'b0, d}, {2'b0, 8'h3C});
    busRead(2'd2, d);
    check("R9 write does not clear", {2'b0, d & 8'h2E}, {2'b0, expRx(1, 0, 0, 0)});
    busRead(2'd3, d);
    busRead(2'd2, d);
    check("R9 cleared", {2'b0, d & 8'h2E}, {2'b0, 8'h00});
    captureTx(f);
    check("R2 frame 77", f, expFrame(8'h77));

    // R5 overrun
    sendRx(8'h11, -1, 1'b1);
    sendRx(8'h22, -1, 1'b1);
    busRead(2'd2, d);
    check("R5 overrun", {2'b0, d & 8'h2E}, {2'b0, expRx(1, 1, 0, 0)});
    busRead(2'd3, d);
    check("R5 first kept", {2'b0, d}, {2'b0, 8'h11});

    // R6 noise
    sendRx(8'h5A, 4, 1'b1);
    busRead(2'd2, d);
    check("R6 noise", {2'b0, d & 8'h2E}, {2'b0, expRx(1, 0, 1, 0)});
    busRead(2'd3, d);
    check("R6 majority data", {2'b0, d}, {2'b0, 8'h5A});

    // R7 framing
    sendRx(8'h81, -1, 1'b0);
    busRead(2'd2, d);
    check("R7 framing", {2'b0, d & 8'h2E}, {2'b0, expRx(1, 0, 0, 1)});
    busRead(2'd3, d);
    check("R7 data", {2'b0, d}, {2'b0, 8'h81});

    // R8 idle
    waitClk(12 * BIT_CLKS);
    clearRx();
    sendRx(8'hC3, -1, 1'b1);
    busRead(2'd2, d);
    check("R8 idle not yet", {9'b0, d[4]}, 10'd0);
    waitClk(11 * BIT_CLKS);
    busRead(2'd2, d);
    check("R8 idle set", {9'b0, d[4]}, 10'd1);
    busRead(2'd3, d);

    // R10 sleep and wake
    busWrite(2'd1, 8'h01);
    sendRx(8'h99, -1, 1'b1);
    busRead(2'd2, d);
    check("R10 no flags asleep", {2'b0, d & 8'h3E}, {2'b0, 8'h00});
    busRead(2'd1, d);
    check("R10 still asleep", {9'b0, d[0]}, 10'd1);
    waitClk(11 * BIT_CLKS);
    busRead(2'd1, d);
    check("R10 woke", {9'b0, d[0]}, 10'd0);
    sendRx(8'h42, -1, 1'b1);
    busRead(2'd2, d);
    check("R10 rx after wake", {2'b0, d & 8'h2E}, {2'b0, expRx(1, 0, 0, 0)});
    busRead(2'd3, d);
    check("R10 data after wake", {2'b0, d}, {2'b0, 8'h42});

    // random transmit and receive
    for (int i = 0; i < 5; i++) begin
      logic [7:0] b;
      b = 8'($urandom);
      busWrite(2'd3, b);
      captureTx(f);
      check("R2 random tx", f, expFrame(b));
      waitClk(40);
      b = 8'($urandom);
      sendRx(b, -1, 1'b1);
      busRead(2'd2, d);
      check("R4 random status", {2'b0, d & 8'h2E}, {2'b0, expRx(1, 0, 0, 0)});
      busRead(2'd3, d);
      check("R4 random data", {2'b0, d}, {2'b0, b});
    end

    // R11 break
    busWrite(2'd1, 8'h02);
    waitClk(5);
    bad = 0;
    for (int i = 0; i < 50; i++) begin
      if (txLine !== 1'b0) bad++;
      waitClk(BIT_CLKS / 2);
    end
    check("R11 continuous low", 10'(bad), 10'd0);
    busWrite(2'd1, 8'h00);
    waitClk(11 * BIT_CLKS);
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      if (txLine !== 1'b1) bad++;
      waitClk(8);
    end
    check("R11 released high", 10'(bad), 10'd0);

    // R12 enables off
    clearRx();
    busWrite(2'd0, 8'h00);
    sendRx(8'h66, -1, 1'b1);
    busRead(2'd2, d);
    check("R12 rx disabled", {2'b0, d & 8'h3E}, {2'b0, 8'h00});
    busWrite(2'd3, 8'h55);
    bad = 0;
    for (int i = 0; i < 100; i++) begin
      if (txLine !== 1'b1) bad++;
      waitClk(8);
    end
    check("R12 tx disabled", 10'(bad), 10'd0);

    if (seed == 0) $display("seed zero");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule